// File: doc/BRIEF.md
# Phase-Locked Sine and Triangle Sample Generator

This block produces two periodic digital waveforms, a sine and a triangle, that run at the same frequency and stay locked in phase. One free-running phase counter feeds both. The counter value addresses a full-period sine table, and the same value is folded arithmetically into a symmetric triangle. Each waveform is captured in its own signed output register. The counter advances once per clock, so each waveform repeats every 256 clocks with the default 8-bit phase. That gives an output frequency of the clock frequency divided by 256.

The clear input is active low. It clears the phase counter and both output registers at once, and both waveforms restart together. The clear takes effect asynchronously. Its release passes through a two-stage synchronizer before the counter starts. A count-enable input can pause the whole generator: while it is low, the counter and both samples hold their values. Typical use is a test-pattern or reference-tone source whose two outputs feed a converter model or a data logger.

Top module: `wavegen_top`

## Requirements
- R1: While `clr_n` is low, `sine_q`, `tri_q` and the internal phase all read zero, and they go to zero without waiting for a clock edge.
- R2: After `clr_n` rises, the outputs stay zero through the next two rising clock edges. The third rising edge, with `run_en` high, loads the samples for phase 0.
- R3: With `run_en` high, the phase advances by one on every rising edge and wraps from 255 to 0, so each waveform repeats every 256 enabled clocks.
- R4: The sine sample for phase n is round(127·sin(2π·n/256)) in 8-bit two's complement. It stays within −127 to +127 and never reads −128.
- R5: The triangle sample for phase n is 2n−128 for n from 0 to 127, and 2·(255−n)−128 for n from 128 to 255, in 8-bit two's complement. Every triangle sample is even.
- R6: Both outputs show the sample of the phase value that was present one enabled clock earlier. This latency is the same for both waveforms, so phase 0 gives a sine of 0 together with a triangle of −128.
- R7: While `run_en` is low, the phase, `sine_q` and `tri_q` all keep their values. When `run_en` goes high again, the sequence resumes at the next phase.
- R8: A clear applied in the middle of a run restarts both waveforms from phase 0, following the same release timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all registers load on its rising edge |
| clr_n | input | 1 | Active-low clear, asynchronous assertion, synchronized release |
| run_en | input | 1 | Count enable; low holds the phase and both samples |
| sine_q | output | 8 | Signed two's-complement sine sample |
| tri_q | output | 8 | Signed two's-complement triangle sample |

## Verification
The assertions assume that `clr_n` is either low or high at every rising edge and never unknown once the run has started. They also assume `run_en` is stable around each edge, because the hold and step properties read it at the same edge as the phase. The bench changes `clr_n` and `run_en` only on falling edges, so every rising edge sees settled control values. It exercises pauses and a mid-run clear only after at least one full period has run without interruption.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  localparam int PHASE_W_DEF  = 8;
  localparam int SAMPLE_W_DEF = 8;
  localparam int SYNC_STAGES  = 2;
  localparam real TWO_PI      = 6.283185307179586;

  // Rounded, clamped sine sample for table slot n of a depth-entry period.
  function automatic int sine_value(input int n, input int depth, input int amp);
    real x;
    int  r;
    x = real'(amp) * $sin(TWO_PI * real'(n) / real'(depth));
    if (x >= 0.0) r = $rtoi(x + 0.5);
    else          r = -$rtoi(0.5 - x);
    if (r > amp)  r = amp;
    if (r < -amp) r = -amp;
    return r;
  endfunction

endpackage

// File: rtl/wg_reset_sync.sv
module wg_reset_sync #(
  parameter int STAGES = wavegen_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wg_phase_counter.sv
module wg_phase_counter #(
  parameter int PHASE_W = wavegen_pkg::PHASE_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] phase_d;

  always_comb begin
    phase_d = phase;
    if (step_en) phase_d = phase + PHASE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/wg_sine_rom.sv
module wg_sine_rom #(
  parameter int PHASE_W  = wavegen_pkg::PHASE_W_DEF,
  parameter int SAMPLE_W = wavegen_pkg::SAMPLE_W_DEF
) (
  input  logic [PHASE_W-1:0]         addr,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam int DEPTH = 1 << PHASE_W;
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int VAL = wavegen_pkg::sine_value(i, DEPTH, AMP);
    assign table_w[i] = VAL[SAMPLE_W-1:0];
  end

  assign sample = table_w[addr];
endmodule

// File: rtl/wg_triangle_fold.sv
module wg_triangle_fold #(
  parameter int PHASE_W = wavegen_pkg::PHASE_W_DEF
) (
  input  logic [PHASE_W-1:0]        phase,
  output logic signed [PHASE_W-1:0] sample
);
  logic [PHASE_W-2:0] folded;

  always_comb begin
    // Second half mirrors the first: the lower bits count back down.
    folded = phase[PHASE_W-1] ? ~phase[PHASE_W-2:0] : phase[PHASE_W-2:0];
    // Double the folded count, then shift the range down by half scale.
    sample = {~folded[PHASE_W-2], folded[PHASE_W-3:0], 1'b0};
  end
endmodule

// File: rtl/wg_sample_reg.sv
module wg_sample_reg #(
  parameter int W = wavegen_pkg::SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);
  logic signed [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top #(
  parameter int PHASE_W  = wavegen_pkg::PHASE_W_DEF,
  parameter int SAMPLE_W = wavegen_pkg::SAMPLE_W_DEF
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       run_en,
  output logic signed [SAMPLE_W-1:0] sine_q,
  output logic signed [SAMPLE_W-1:0] tri_q
);
  localparam int NUM_CH = 2;

  logic                       rst_sync_n;
  logic [PHASE_W-1:0]         phase;
  logic signed [SAMPLE_W-1:0] ch_d [NUM_CH];
  logic signed [SAMPLE_W-1:0] ch_q [NUM_CH];

  wg_reset_sync #(.STAGES(wavegen_pkg::SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (clr_n),
    .srst_n (rst_sync_n)
  );

  wg_phase_counter #(.PHASE_W(PHASE_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (run_en),
    .phase   (phase)
  );

  wg_sine_rom #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_sine (
    .addr   (phase),
    .sample (ch_d[0])
  );

  wg_triangle_fold #(.PHASE_W(PHASE_W)) u_tri (
    .phase  (phase),
    .sample (ch_d[1])
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    wg_sample_reg #(.W(SAMPLE_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load_en (run_en),
      .d       (ch_d[c]),
      .q       (ch_q[c])
    );
  end

  assign sine_q = ch_q[0];
  assign tri_q  = ch_q[1];
endmodule

// File: rtl/wavegen_chk.sv
module wavegen_chk #(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       clr_n,
  input logic                       run_en,
  input logic                       rst_sync_n,
  input logic [PHASE_W-1:0]         phase,
  input logic signed [SAMPLE_W-1:0] sine_q,
  input logic signed [SAMPLE_W-1:0] tri_q
);
  localparam logic signed [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !rst_sync_n |-> (sine_q == '0 && tri_q == '0 && phase == '0));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (rst_sync_n && run_en) |=> (phase == $past(phase) + PHASE_W'(1)));

  assert_sine_range_R4: assert property (@(posedge clk) disable iff (!clr_n)
    sine_q != NEG_FULL);

  assert_tri_even_R5: assert property (@(posedge clk) disable iff (!clr_n)
    tri_q[0] == 1'b0);

  assert_phase_lock_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (rst_sync_n && run_en && phase == '0) |=> (sine_q == '0 && tri_q == NEG_FULL));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (rst_sync_n && !run_en) |=> ($stable(phase) && $stable(sine_q) && $stable(tri_q)));
endmodule

bind wavegen_top wavegen_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .run_en     (run_en),
  .rst_sync_n (rst_sync_n),
  .phase      (phase),
  .sine_q     (sine_q),
  .tri_q      (tri_q)
);

// File: tb/wavegen_top_tb.sv
`timescale 1ns/1ps
module wavegen_top_tb;
  logic              clk = 1'b0;
  logic              clr_n;
  logic              run_en;
  logic signed [7:0] sine_q;
  logic signed [7:0] tri_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wavegen_top u_dut (
    .clk    (clk),
    .clr_n  (clr_n),
    .run_en (run_en),
    .sine_q (sine_q),
    .tri_q  (tri_q)
  );

  function automatic int exp_sine(input int n);
    real x;
    x = 127.0 * $sin(6.283185307179586 * real'(n) / 256.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  function automatic int exp_tri(input int n);
    return (n < 128) ? (2 * n - 128) : (2 * (255 - n) - 128);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called just after a falling edge: compare both outputs with phase n.
  task automatic check_phase(input string tag, input int n);
    check({tag, " sine"}, int'(sine_q), exp_sine(n % 256));
    check({tag, " tri"},  int'(tri_q),  exp_tri(n % 256));
  endtask

  // Release the clear at a falling edge, then check the R2 timing.
  task automatic release_clear(input string tag);
    clr_n = 1'b1;
    for (int e = 0; e < 2; e++) begin
      @(negedge clk);
      check({tag, " R2 held sine"}, int'(sine_q), 0);
      check({tag, " R2 held tri"},  int'(tri_q),  0);
    end
    @(negedge clk);
    check_phase({tag, " R2/R6 first sample"}, 0);
  endtask

  initial begin
    clr_n  = 1'b0;
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset sine", int'(sine_q), 0);
    check("R1 reset tri",  int'(tri_q),  0);

    release_clear("start");
    // Two full periods, covering the 255 -> 0 wrap (R3, R4, R5, R6).
    for (int k = 1; k < 520; k++) begin
      @(negedge clk);
      check_phase("R3/R4/R5 sweep", k);
    end

    // Pause for three clocks, then resume (R7). The last shown phase is 519.
    run_en = 1'b0;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      check_phase("R7 hold", 519);
    end
    run_en = 1'b1;
    for (int k = 520; k < 530; k++) begin
      @(negedge clk);
      check_phase("R7 resume", k);
    end

    // Alternate enable: samples advance only on enabled edges (R7).
    for (int k = 530; k < 560; k++) begin
      run_en = 1'b0;
      @(negedge clk);
      check_phase("R7 gap", k - 1);
      run_en = 1'b1;
      @(negedge clk);
      check_phase("R7 step", k);
    end

    // Clear in the middle of a run (R1, R8).
    #1 clr_n = 1'b0;
    #1;
    check("R1 async sine", int'(sine_q), 0);
    check("R1 async tri",  int'(tri_q),  0);
    @(negedge clk);
    @(negedge clk);
    check("R8 cleared sine", int'(sine_q), 0);
    release_clear("R8 restart");
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      check_phase("R8 rerun", k);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule